// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Logic

This block produces the receive-side interrupt conditions of a 16550-style UART that runs with its FIFOs enabled. It sits beside the receive FIFO and does not hold the FIFO storage. It watches a push strobe from the deserializer, a CPU pop strobe and the FIFO occupancy count. From these it derives three outputs: the data-ready status bit, a trigger-level interrupt and a character-timeout interrupt. It also gives a 4-bit interrupt identification code that ranks these interrupts against a receiver line-status condition.

The character-timeout timer counts ticks of a 16x baud clock enable. Because of this, the timeout delay follows the programmed baud rate. The limit is four character times for the programmed frame (start, data, parity and stop bits). The timer restarts on every push and every pop while no timeout is pending. Once a timeout is pending, only a CPU pop clears it. The push and pop inputs are single-cycle strobes, one per character. The FIFO beside the block has already applied them, so this block never applies back-pressure and has no handshake. All other pins are plain level controls and status.

Top module: `uart_rx_irq`

## Requirements
- R1: `trig_irq` and `tmo_irq` are low whenever `fifo_en` or `rx_irq_en` is low. In that state, with no line-status condition, `irq_id` is 4'h1.
- R2: With both enables high and a non-zero `trig_level`, `trig_irq` is high exactly while `fifo_count >= trig_level`. It falls as soon as the count drops below the level. A `trig_level` of zero never raises it.
- R3: `data_ready` is high in the cycle after a push. It goes low in the cycle after a cycle in which `fifo_count` was zero and no push occurred. It is low after reset.
- R4: The timeout limit in 16x ticks is 4 x 16 x (1 + data bits + parity bit + stop bits). Data bits are 5 + `data_len`. The parity bit is 1 when `parity_en` is high. Stop bits are 2 when `two_stop` is high, otherwise 1. Examples: 448 ticks for 5 data bits, no parity and 1 stop bit; 768 ticks for 8 data bits, parity and 2 stop bits.
- R5: The timer advances on `baud_tick` while the FIFO is not empty and no push or pop occurs. The tick that completes the limit makes a timeout pending. `tmo_irq` then rises in the next cycle, provided both enables are high.
- R6: While no timeout is pending, a push or a pop restarts the count from zero. An empty FIFO also holds the count at zero.
- R7: A pending timeout survives further pushes. It is cleared, and the timer restarted, by the cycle after a pop.
- R8: `irq_id` encodes the highest-priority condition. 4'h6 means a line-status error (`line_err` with `ls_irq_en` and `fifo_en`). 4'hC means a timeout, 4'h4 means trigger level reached, and 4'h1 means nothing is pending. A timeout outranks trigger level.
- R9: With `fifo_en` low, the timer, the pending timeout and `data_ready` are all cleared at the next clock edge.
- R10: Cycles without `baud_tick` do not advance the timer. With ticks on every second cycle, the timeout takes twice as many clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_irq_en | input | 1 | Receive-data interrupt enable |
| ls_irq_en | input | 1 | Line-status interrupt enable |
| push | input | 1 | One character written into the receive FIFO this cycle |
| pop | input | 1 | CPU read one character from the receive FIFO this cycle |
| fifo_count | input | CW | FIFO occupancy before this cycle's push/pop |
| trig_level | input | CW | Programmed trigger level (0 disables) |
| data_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits |
| baud_tick | input | 1 | 16x baud clock enable |
| line_err | input | 1 | Receiver line-status error present |
| data_ready | output | 1 | Data-ready status |
| trig_irq | output | 1 | Trigger-level interrupt |
| tmo_irq | output | 1 | Character-timeout interrupt |
| irq_id | output | 4 | Interrupt identification code |

## Verification
A timer that miscounts or restarts at the wrong moment shows up only at the edge of a timeout: `tmo_irq` rises one tick early or late. That can be hundreds of cycles after the push or pop that set up the error. So the bench places the checks at the limit minus one tick and at the limit itself. A pending flag that a push wrongly clears, or a pop wrongly fails to clear, shows in `tmo_irq` and `irq_id` in the very next cycle. A wrong `data_ready` register or a wrong trigger comparison is visible in the same cycle or the one after the count changes.

// File: rtl/uart_rxirq_pkg.sv
package uart_rxirq_pkg;
  typedef enum logic [3:0] {
    IID_NONE = 4'h1,
    IID_DATA = 4'h4,
    IID_LINE = 4'h6,
    IID_TMO  = 4'hC
  } iid_e;
endpackage

// File: rtl/rxirq_char_limit.sv
module rxirq_char_limit #(
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4,
  parameter int TW            = 10
) (
  input  logic [1:0]    data_len,
  input  logic          parity_en,
  input  logic          two_stop,
  output logic [TW-1:0] limit
);
  int unsigned nbits;
  always_comb begin
    // start bit + (5 + data_len) data bits + parity + stop bits
    nbits = 32'd6 + 32'(data_len) + 32'(parity_en) + (two_stop ? 32'd2 : 32'd1);
    limit = TW'(nbits * 32'(TMO_CHARS) * 32'(TICKS_PER_BIT));
  end
endmodule

// File: rtl/rxirq_level.sv
module rxirq_level #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push,
  input  logic [CW-1:0] fifo_count,
  input  logic [CW-1:0] trig_level,
  output logic          nonempty,
  output logic          data_ready,
  output logic          trig_hit
);
  assign nonempty = (fifo_count != '0);
  assign trig_hit = (trig_level != '0) && (fifo_count >= trig_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_ready <= 1'b0;
    else        data_ready <= fifo_en && (push || nonempty);
  end
endmodule

// File: rtl/rxirq_tmo_timer.sv
module rxirq_tmo_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push,
  input  logic          pop,
  input  logic          nonempty,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          pending
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (!fifo_en) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (pending) begin
      if (pop) begin
        pending <= 1'b0;
        cnt     <= '0;
      end
    end else if (push || pop || !nonempty) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt >= limit - TW'(1)) begin
        pending <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + TW'(1);
      end
    end
  end
endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rxirq_pkg::*;
#(
  parameter int CW            = 5,
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          rx_irq_en,
  input  logic          ls_irq_en,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] fifo_count,
  input  logic [CW-1:0] trig_level,
  input  logic [1:0]    data_len,
  input  logic          parity_en,
  input  logic          two_stop,
  input  logic          baud_tick,
  input  logic          line_err,
  output logic          data_ready,
  output logic          trig_irq,
  output logic          tmo_irq,
  output logic [3:0]    irq_id
);
  localparam int MAX_CHAR_BITS = 12;
  localparam int TW = $clog2(TMO_CHARS * TICKS_PER_BIT * MAX_CHAR_BITS + 1);

  logic [TW-1:0] limit;
  logic          nonempty, trig_hit, pending, rx_en, line_act;
  iid_e          id_q;

  rxirq_char_limit #(.TICKS_PER_BIT(TICKS_PER_BIT), .TMO_CHARS(TMO_CHARS), .TW(TW)) lim_i (
    .data_len(data_len), .parity_en(parity_en), .two_stop(two_stop), .limit(limit));

  rxirq_level #(.CW(CW)) lvl_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push),
    .fifo_count(fifo_count), .trig_level(trig_level),
    .nonempty(nonempty), .data_ready(data_ready), .trig_hit(trig_hit));

  rxirq_tmo_timer #(.TW(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push), .pop(pop),
    .nonempty(nonempty), .tick(baud_tick), .limit(limit), .pending(pending));

  assign rx_en    = fifo_en && rx_irq_en;
  assign line_act = fifo_en && ls_irq_en && line_err;
  assign trig_irq = rx_en && trig_hit;
  assign tmo_irq  = rx_en && pending;

  always_comb begin
    if (line_act)      id_q = IID_LINE;
    else if (tmo_irq)  id_q = IID_TMO;
    else if (trig_irq) id_q = IID_DATA;
    else               id_q = IID_NONE;
  end
  assign irq_id = id_q;
endmodule

// File: rtl/uart_rx_irq_chk.sv
module uart_rx_irq_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          rx_irq_en,
  input logic          ls_irq_en,
  input logic          push,
  input logic          pop,
  input logic [CW-1:0] fifo_count,
  input logic          line_err,
  input logic          data_ready,
  input logic          trig_irq,
  input logic          tmo_irq,
  input logic [3:0]    irq_id
);
  a_r1_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_en && rx_irq_en) |-> (!trig_irq && !tmo_irq));
  a_r3_push_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && push) |=> data_ready);
  a_r3_empty_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0 && !push) |=> !data_ready);
  a_r5_tmo_needs_chars: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> (fifo_count != '0));
  a_r6_activity_blocks_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_irq_en && !tmo_irq && (push || pop)) |=> !tmo_irq);
  a_r7_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && pop) |=> !tmo_irq);
  a_r8_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && ls_irq_en && line_err) |-> (irq_id == 4'h6));
  a_r8_tmo_over_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_irq && !(fifo_en && ls_irq_en && line_err)) |-> (irq_id == 4'hC));
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (!tmo_irq && !data_ready));
endmodule

bind uart_rx_irq uart_rx_irq_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
  .ls_irq_en(ls_irq_en), .push(push), .pop(pop), .fifo_count(fifo_count),
  .line_err(line_err), .data_ready(data_ready), .trig_irq(trig_irq),
  .tmo_irq(tmo_irq), .irq_id(irq_id));

// File: tb/uart_rx_irq_tb_top.sv
module uart_rx_irq_tb_top;
  localparam int CW = 5;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, rx_irq_en = 0, ls_irq_en = 0, push = 0, pop = 0;
  logic [CW-1:0] c = '0;
  logic [CW-1:0] trig_level = '0;
  logic [1:0] data_len = 2'd0;
  logic parity_en = 0, two_stop = 0, baud_tick = 0, line_err = 0;
  logic data_ready, trig_irq, tmo_irq;
  logic [3:0] irq_id;

  int checks = 0, errors = 0;
  bit done = 0;

  int  m_cnt = 0;
  bit  m_pend = 0, m_dr = 0;

  always #10 clk = ~clk;

  uart_rx_irq #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
    .ls_irq_en(ls_irq_en), .push(push), .pop(pop), .fifo_count(c),
    .trig_level(trig_level), .data_len(data_len), .parity_en(parity_en),
    .two_stop(two_stop), .baud_tick(baud_tick), .line_err(line_err),
    .data_ready(data_ready), .trig_irq(trig_irq), .tmo_irq(tmo_irq),
    .irq_id(irq_id));

  function automatic int tmo_limit(logic [1:0] dl, logic p, logic ts);
    return 64 * (6 + int'(dl) + int'(p) + (ts ? 2 : 1));
  endfunction

  function automatic bit exp_trig();
    return fifo_en && rx_irq_en && trig_level != 0 && c >= trig_level;
  endfunction

  function automatic bit exp_tmo();
    return fifo_en && rx_irq_en && m_pend;
  endfunction

  function automatic int exp_id();
    if (fifo_en && ls_irq_en && line_err) return 6;
    if (exp_tmo()) return 12;
    if (exp_trig()) return 4;
    return 1;
  endfunction

  // bench FIFO occupancy and requirement model
  always @(posedge clk) begin
    if (!rst_n) begin
      c <= '0; m_cnt <= 0; m_pend <= 0; m_dr <= 0;
    end else begin
      c <= c + CW'(push) - CW'(pop);
      if (!fifo_en) begin
        m_cnt <= 0; m_pend <= 0; m_dr <= 0;
      end else begin
        m_dr <= push || (c != 0);
        if (m_pend) begin
          if (pop) begin m_pend <= 0; m_cnt <= 0; end
        end else if (push || pop || c == 0) begin
          m_cnt <= 0;
        end else if (baud_tick) begin
          if (m_cnt + 1 >= tmo_limit(data_len, parity_en, two_stop)) begin
            m_pend <= 1; m_cnt <= 0;
          end else m_cnt <= m_cnt + 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FIFO irq FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    chk(data_ready == m_dr, "R3 data_ready", int'(data_ready), int'(m_dr));
    chk(trig_irq == exp_trig(), "R2 trig_irq", int'(trig_irq), int'(exp_trig()));
    chk(tmo_irq == exp_tmo(), "R5 tmo_irq", int'(tmo_irq), int'(exp_tmo()));
    chk(int'(irq_id) == exp_id(), "R8 irq_id", int'(irq_id), exp_id());
  endtask

  task automatic step();
    #8;
    compare_all();
    @(negedge clk);
  endtask

  task automatic drain();
    push = 0; baud_tick = 0;
    while (c != 0) begin pop = 1; step(); end
    pop = 0;
  endtask

  task automatic tmo_test(logic [1:0] dl, logic p, logic ts);
    int lim;
    lim = tmo_limit(dl, p, ts);
    data_len = dl; parity_en = p; two_stop = ts;
    fifo_en = 1; rx_irq_en = 1; ls_irq_en = 0; line_err = 0; trig_level = 5'd14;
    baud_tick = 0;
    push = 1; step(); step(); push = 0;
    baud_tick = 1;
    repeat (lim - 1) step();
    chk(tmo_irq == 0, "R4 R5 one tick before limit", int'(tmo_irq), 0);
    step();
    chk(tmo_irq == 1, "R4 R5 at limit", int'(tmo_irq), 1);
    chk(irq_id == 4'hC, "R8 timeout code", int'(irq_id), 12);
    push = 1; step(); push = 0;
    chk(tmo_irq == 1, "R7 push keeps timeout", int'(tmo_irq), 1);
    pop = 1; step(); pop = 0;
    chk(tmo_irq == 0, "R7 pop clears timeout", int'(tmo_irq), 0);
    repeat (lim - 1) step();
    pop = 1; step(); pop = 0;
    repeat (lim - 1) step();
    chk(tmo_irq == 0, "R6 pop restarted timer", int'(tmo_irq), 0);
    step();
    chk(tmo_irq == 1, "R6 timeout after restart", int'(tmo_irq), 1);
    fifo_en = 0; step();
    chk(tmo_irq == 0, "R9 disable clears timeout", int'(tmo_irq), 0);
    chk(data_ready == 0, "R9 disable clears data_ready", int'(data_ready), 0);
    fifo_en = 1; baud_tick = 0; step();
    repeat (lim - 1) begin baud_tick = 1; step(); baud_tick = 0; step(); end
    chk(tmo_irq == 0, "R10 half-rate ticks not yet", int'(tmo_irq), 0);
    baud_tick = 1; step(); baud_tick = 0;
    chk(tmo_irq == 1, "R10 half-rate ticks reach limit", int'(tmo_irq), 1);
    ls_irq_en = 1; line_err = 1; #1;
    chk(irq_id == 4'h6, "R8 line status first", int'(irq_id), 6);
    step(); ls_irq_en = 0; line_err = 0;
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(data_ready == 0, "R3 reset data_ready", int'(data_ready), 0);
    chk(tmo_irq == 0 && trig_irq == 0, "R1 reset irqs", int'(tmo_irq) + int'(trig_irq), 0);
    chk(irq_id == 4'h1, "R8 reset id", int'(irq_id), 1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: receive interrupt enable off masks trigger level
    fifo_en = 1; rx_irq_en = 0; trig_level = 5'd1;
    push = 1; step(); push = 0; #1;
    chk(trig_irq == 0, "R1 masked trigger", int'(trig_irq), 0);
    chk(irq_id == 4'h1, "R1 masked id", int'(irq_id), 1);
    rx_irq_en = 1; #1;
    chk(trig_irq == 1, "R2 trigger reached", int'(trig_irq), 1);
    chk(irq_id == 4'h4, "R8 data code", int'(irq_id), 4);
    step();
    trig_level = 5'd0; #1;
    chk(trig_irq == 0, "R2 zero level", int'(trig_irq), 0);
    step();
    drain(); step();
    chk(data_ready == 0, "R3 cleared after empty", int'(data_ready), 0);

    tmo_test(2'd0, 1'b0, 1'b0);
    tmo_test(2'd3, 1'b1, 1'b1);

    // constrained random phase
    void'($urandom(32'd7331));
    for (int seg = 0; seg < 40; seg++) begin
      int rate, tick_mode;
      data_len   = 2'($urandom_range(0, 3));
      parity_en  = 1'($urandom_range(0, 1));
      two_stop   = 1'($urandom_range(0, 1));
      fifo_en    = ($urandom_range(0, 9) != 0);
      rx_irq_en  = ($urandom_range(0, 5) != 0);
      ls_irq_en  = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 4))
        0: trig_level = 5'd0;  1: trig_level = 5'd1;
        2: trig_level = 5'd4;  3: trig_level = 5'd8;
        default: trig_level = 5'd14;
      endcase
      rate      = (seg % 3 == 0) ? 0 : int'($urandom_range(4, 40));
      tick_mode = int'($urandom_range(1, 3));
      for (int k = 0; k < 1000; k++) begin
        if (rate == 0) begin
          push = (k < 3) && (c < DEPTH);
          pop  = 0;
        end else begin
          push = ($urandom_range(0, rate) == 0) && (c < DEPTH);
          pop  = ($urandom_range(0, rate) == 0) && (c != 0);
        end
        baud_tick = ($urandom_range(1, tick_mode) == 1);
        line_err  = ($urandom_range(0, 60) == 0);
        step();
      end
    end
    push = 0; pop = 0; line_err = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FIFO irq FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule